// File: doc/BRIEF.md
# Immediate-Shift, Word-Arithmetic and Upper-Immediate Execute Unit

This block is a purely combinational slice of the execute stage of a 64-bit integer core. It takes a 32-bit instruction word, the 64-bit first source operand and the current program counter, and it produces the destination value in the same cycle. It also drives a flag that qualifies the result, and a second flag that marks an encoding set aside for future use.

It covers four groups of operations:

- 64-bit shifts by an immediate amount.
- 32-bit "word" forms of the add-immediate and the shifts. These read only the low half of the operand and return a sign-extended 32-bit value.
- Load-upper-immediate.
- Add-upper-immediate-to-PC.

A small decoder classifies the instruction into an enumerated operation kind. Every result path reads that kind.

Top module: `imm_exec_unit`

## Requirements
- R1: For opcode 0010011 with funct3 001 and instruction bits 31..26 equal to 000000, rd is rs1 shifted left by instruction bits 25..20, with zeros entering at the bottom; valid is high.
- R2: For opcode 0010011 with funct3 101, rd is rs1 shifted right by instruction bits 25..20. Bits 31..26 equal to 000000 select a zero fill. Bits 31..26 equal to 010000 select a fill with copies of rs1 bit 63. Valid is high in both cases.
- R3: For opcode 0011011 with funct3 000, rd is the low 32 bits of rs1 plus the sign-extended 12-bit immediate in bits 31..20, with carries beyond bit 31 dropped and the 32-bit sum sign-extended to 64 bits.
- R4: For opcode 0011011 with funct3 001 or 101 and instruction bit 25 clear, the low 32 bits of rs1 are shifted by bits 24..20 and the 32-bit outcome is sign-extended. The accepted values of bits 31..25 are 0000000 for a left shift, 0000000 for a zero-fill right shift and 0100000 for a sign-fill right shift from bit 31.
- R5: Every operation under opcode 0011011 gives the same rd whatever rs1 bits 63..32 hold, and rd bits 63..31 all equal rd bit 31.
- R6: For opcode 0011011 with funct3 001 or 101 and instruction bit 25 set, reserved is high, valid is low and rd is zero; reserved is never high together with valid.
- R7: For opcode 0110111, rd holds instruction bits 31..12 in bits 31..12 and zeros in bits 11..0, sign-extended from bit 31 to 64 bits.
- R8: For opcode 0010111, rd is the PC plus the same sign-extended upper value as in R7, wrapping modulo 2^64.
- R9: Any other opcode, funct3 or upper-bit pattern drives valid low, reserved low and rd to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| instr_i | input | 32 | Instruction word to execute |
| rs1_i | input | 64 | First source operand |
| pc_i | input | 64 | Program counter of the instruction |
| rd_o | output | 64 | Destination result, zero when not valid |
| valid_o | output | 1 | Result belongs to a handled operation |
| reserved_o | output | 1 | Word shift with a reserved amount bit |

## Verification
Every result and both flags are due zero cycles after the inputs change, because no register lies between any input and any output. The bench changes inputs just after a rising clock edge and samples half a period later, on the falling edge, so each check sees settled values for exactly the vector applied in that cycle. The shift amounts are swept in full for both widths against several operand patterns. The reserved sweep and the unsupported-encoding sweep read all three outputs in the same sample.

// File: rtl/iex_pkg.sv
package iex_pkg;

    localparam logic [6:0] OPC_IMM    = 7'b0010011;
    localparam logic [6:0] OPC_IMM_W  = 7'b0011011;
    localparam logic [6:0] OPC_LDUP   = 7'b0110111;
    localparam logic [6:0] OPC_PCUP   = 7'b0010111;

    localparam logic [2:0] F3_ADD     = 3'b000;
    localparam logic [2:0] F3_SHL     = 3'b001;
    localparam logic [2:0] F3_SHR     = 3'b101;

    typedef enum logic [3:0] {
        IEX_NONE,
        IEX_SHL,
        IEX_SHR_LOG,
        IEX_SHR_ARI,
        IEX_ADDW,
        IEX_SHLW,
        IEX_SHRW_LOG,
        IEX_SHRW_ARI,
        IEX_LDUP,
        IEX_PCUP,
        IEX_RSVD
    } iex_op_e;

    typedef struct packed {
        iex_op_e     op;
        logic [5:0]  shamt;
        logic [11:0] imm12;
        logic [19:0] uimm;
    } iex_dec_t;

endpackage

// File: rtl/iex_decode.sv
module iex_decode
    import iex_pkg::*;
#(
    parameter int ILEN = 32
) (
    input  logic [ILEN-1:0] instr_i,
    output iex_dec_t        dec_o
);

    logic [6:0] opcode;
    logic [2:0] funct3;
    logic [5:0] top6;
    logic [6:0] top7;
    iex_op_e    kind;

    assign opcode = instr_i[6:0];
    assign funct3 = instr_i[14:12];
    assign top6   = instr_i[31:26];
    assign top7   = instr_i[31:25];

    always_comb begin
        kind = IEX_NONE;
        unique case (opcode)
            OPC_IMM: begin
                if (funct3 == F3_SHL && top6 == 6'b000000) begin
                    kind = IEX_SHL;
                end else if (funct3 == F3_SHR && top6 == 6'b000000) begin
                    kind = IEX_SHR_LOG;
                end else if (funct3 == F3_SHR && top6 == 6'b010000) begin
                    kind = IEX_SHR_ARI;
                end
            end
            OPC_IMM_W: begin
                if (funct3 == F3_ADD) begin
                    kind = IEX_ADDW;
                end else if (funct3 == F3_SHL || funct3 == F3_SHR) begin
                    if (instr_i[25]) begin
                        kind = IEX_RSVD;
                    end else if (funct3 == F3_SHL && top7 == 7'b0000000) begin
                        kind = IEX_SHLW;
                    end else if (funct3 == F3_SHR && top7 == 7'b0000000) begin
                        kind = IEX_SHRW_LOG;
                    end else if (funct3 == F3_SHR && top7 == 7'b0100000) begin
                        kind = IEX_SHRW_ARI;
                    end
                end
            end
            OPC_LDUP: kind = IEX_LDUP;
            OPC_PCUP: kind = IEX_PCUP;
            default:  kind = IEX_NONE;
        endcase
    end

    assign dec_o.op    = kind;
    assign dec_o.shamt = instr_i[25:20];
    assign dec_o.imm12 = instr_i[31:20];
    assign dec_o.uimm  = instr_i[31:12];

endmodule

// File: rtl/iex_shifter.sv
module iex_shifter #(
    parameter int W   = 64,
    parameter int SHW = $clog2(W)
) (
    input  logic [W-1:0]   value_i,
    input  logic [SHW-1:0] shamt_i,
    input  logic           left_i,
    input  logic           arith_i,
    output logic [W-1:0]   result_o
);

    logic [W-1:0] flipped_in;
    logic [W-1:0] flipped_out;
    logic         fill;
    logic [W-1:0] stg [SHW+1];

    always_comb begin
        for (int i = 0; i < W; i++) begin
            flipped_in[i] = value_i[W-1-i];
        end
    end

    assign fill   = arith_i & ~left_i & value_i[W-1];
    assign stg[0] = left_i ? flipped_in : value_i;

    for (genvar k = 0; k < SHW; k++) begin : g_stage
        localparam int D = 2 ** k;
        assign stg[k+1] = shamt_i[k] ? {{D{fill}}, stg[k][W-1:D]} : stg[k];
    end

    always_comb begin
        for (int i = 0; i < W; i++) begin
            flipped_out[i] = stg[SHW][W-1-i];
        end
    end

    assign result_o = left_i ? flipped_out : stg[SHW];

endmodule

// File: rtl/iex_upper.sv
module iex_upper #(
    parameter int XLEN = 64,
    parameter int UW   = 20,
    parameter int LOW  = 12
) (
    input  logic [UW-1:0]   uimm_i,
    input  logic [XLEN-1:0] pc_i,
    input  logic            add_pc_i,
    output logic [XLEN-1:0] result_o
);

    localparam int VW = UW + LOW;

    logic [VW-1:0]   word;
    logic [XLEN-1:0] wide;

    assign word     = {uimm_i, {LOW{1'b0}}};
    assign wide     = {{(XLEN-VW){word[VW-1]}}, word};
    assign result_o = add_pc_i ? (pc_i + wide) : wide;

endmodule

// File: rtl/imm_exec_unit.sv
module imm_exec_unit
    import iex_pkg::*;
#(
    parameter int XLEN = 64,
    parameter int WLEN = 32,
    parameter int ILEN = 32
) (
    input  logic [ILEN-1:0] instr_i,
    input  logic [XLEN-1:0] rs1_i,
    input  logic [XLEN-1:0] pc_i,
    output logic [XLEN-1:0] rd_o,
    output logic            valid_o,
    output logic            reserved_o
);

    localparam int XSH = $clog2(XLEN);
    localparam int WSH = $clog2(WLEN);
    localparam int IMW = 12;

    iex_dec_t        dec;
    logic [XLEN-1:0] sh_x;
    logic [WLEN-1:0] sh_w;
    logic [WLEN-1:0] sum_w;
    logic [XLEN-1:0] upper_x;
    logic [XLEN-1:0] res;
    logic            ok;

    function automatic logic [XLEN-1:0] widen(input logic [WLEN-1:0] w);
        return {{(XLEN-WLEN){w[WLEN-1]}}, w};
    endfunction

    iex_decode #(.ILEN(ILEN)) u_dec (
        .instr_i (instr_i),
        .dec_o   (dec)
    );

    iex_shifter #(.W(XLEN), .SHW(XSH)) u_shx (
        .value_i  (rs1_i),
        .shamt_i  (dec.shamt[XSH-1:0]),
        .left_i   (dec.op == IEX_SHL),
        .arith_i  (dec.op == IEX_SHR_ARI),
        .result_o (sh_x)
    );

    iex_shifter #(.W(WLEN), .SHW(WSH)) u_shw (
        .value_i  (rs1_i[WLEN-1:0]),
        .shamt_i  (dec.shamt[WSH-1:0]),
        .left_i   (dec.op == IEX_SHLW),
        .arith_i  (dec.op == IEX_SHRW_ARI),
        .result_o (sh_w)
    );

    iex_upper #(.XLEN(XLEN), .UW(20), .LOW(12)) u_up (
        .uimm_i   (dec.uimm),
        .pc_i     (pc_i),
        .add_pc_i (dec.op == IEX_PCUP),
        .result_o (upper_x)
    );

    assign sum_w = rs1_i[WLEN-1:0] + {{(WLEN-IMW){dec.imm12[IMW-1]}}, dec.imm12};

    always_comb begin
        res = '0;
        ok  = 1'b1;
        unique case (dec.op)
            IEX_SHL, IEX_SHR_LOG, IEX_SHR_ARI:    res = sh_x;
            IEX_ADDW:                             res = widen(sum_w);
            IEX_SHLW, IEX_SHRW_LOG, IEX_SHRW_ARI: res = widen(sh_w);
            IEX_LDUP, IEX_PCUP:                   res = upper_x;
            default: begin
                res = '0;
                ok  = 1'b0;
            end
        endcase
    end

    assign rd_o       = res;
    assign valid_o    = ok;
    assign reserved_o = (dec.op == IEX_RSVD);

endmodule

// File: rtl/iex_checker.sv
module iex_checker #(
    parameter int XLEN = 64,
    parameter int WLEN = 32,
    parameter int ILEN = 32
) (
    input logic [ILEN-1:0] instr_i,
    input logic [XLEN-1:0] rd_o,
    input logic            valid_o,
    input logic            reserved_o
);

    logic [6:0] opc;
    logic [2:0] f3;

    assign opc = instr_i[6:0];
    assign f3  = instr_i[14:12];

    always_comb begin
        p_rsvd_not_valid_r6: assert (!(valid_o && reserved_o));
        if (reserved_o) begin
            p_rsvd_only_wshift_r6: assert (opc == 7'b0011011 && instr_i[25]
                                           && (f3 == 3'b001 || f3 == 3'b101));
        end
        if (!valid_o) begin
            p_idle_zero_r9: assert (rd_o == '0);
        end
        if (valid_o && opc == 7'b0011011) begin
            p_word_sext_r5: assert ((&rd_o[XLEN-1:WLEN-1]) || !(|rd_o[XLEN-1:WLEN-1]));
        end
        if (valid_o && opc == 7'b0110111) begin
            p_upper_low_zero_r7: assert (rd_o[11:0] == 12'h000
                && ((&rd_o[XLEN-1:WLEN-1]) || !(|rd_o[XLEN-1:WLEN-1])));
        end
    end

endmodule

bind imm_exec_unit iex_checker #(.XLEN(XLEN), .WLEN(WLEN), .ILEN(ILEN)) u_chk (
    .instr_i    (instr_i),
    .rd_o       (rd_o),
    .valid_o    (valid_o),
    .reserved_o (reserved_o)
);

// File: tb/tb_imm_exec_unit.sv
`timescale 1ns/1ps
module tb_imm_exec_unit;

    logic        clk = 1'b0;
    logic [31:0] instr = 32'h0;
    logic [63:0] rs1 = 64'h0;
    logic [63:0] pc = 64'h0;
    logic [63:0] rd;
    logic        valid;
    logic        rsvd;

    int n_chk = 0;
    int n_bad = 0;
    logic [63:0] seed = 64'h9E37_79B9_7F4A_7C15;

    always #10 clk = ~clk;

    imm_exec_unit dut (
        .instr_i    (instr),
        .rs1_i      (rs1),
        .pc_i       (pc),
        .rd_o       (rd),
        .valid_o    (valid),
        .reserved_o (rsvd)
    );

    function automatic logic [63:0] sx(input logic [31:0] w);
        return {{32{w[31]}}, w};
    endfunction

    function automatic logic [31:0] enc_i(input logic [11:0] imm, input logic [2:0] f3,
                                          input logic [6:0] op);
        return {imm, 5'd5, f3, 5'd7, op};
    endfunction

    function automatic logic [31:0] enc_u(input logic [19:0] u, input logic [6:0] op);
        return {u, 5'd7, op};
    endfunction

    task automatic rnd(output logic [63:0] v);
        seed = seed ^ (seed << 13);
        seed = seed ^ (seed >> 7);
        seed = seed ^ (seed << 17);
        v = seed;
    endtask

    task automatic model(input logic [31:0] ins, input logic [63:0] a, input logic [63:0] p,
                         output logic [63:0] r, output logic v, output logic rs);
        logic [5:0]  sh;
        logic [4:0]  s5;
        logic [31:0] w;
        logic [2:0]  f3;
        sh = ins[25:20];
        s5 = ins[24:20];
        f3 = ins[14:12];
        r  = 64'h0;
        v  = 1'b0;
        rs = 1'b0;
        case (ins[6:0])
            7'b0010011: begin
                if (f3 == 3'b001 && ins[31:26] == 6'b000000) begin
                    r = a << sh; v = 1'b1;
                end else if (f3 == 3'b101 && ins[31:26] == 6'b000000) begin
                    r = a >> sh; v = 1'b1;
                end else if (f3 == 3'b101 && ins[31:26] == 6'b010000) begin
                    r = $signed(a) >>> sh; v = 1'b1;
                end
            end
            7'b0011011: begin
                if (f3 == 3'b000) begin
                    w = a[31:0] + {{20{ins[31]}}, ins[31:20]};
                    r = sx(w); v = 1'b1;
                end else if (f3 == 3'b001 || f3 == 3'b101) begin
                    if (ins[25]) begin
                        rs = 1'b1;
                    end else if (f3 == 3'b001 && ins[31:25] == 7'b0000000) begin
                        w = a[31:0] << s5; r = sx(w); v = 1'b1;
                    end else if (f3 == 3'b101 && ins[31:25] == 7'b0000000) begin
                        w = a[31:0] >> s5; r = sx(w); v = 1'b1;
                    end else if (f3 == 3'b101 && ins[31:25] == 7'b0100000) begin
                        w = $signed(a[31:0]) >>> s5; r = sx(w); v = 1'b1;
                    end
                end
            end
            7'b0110111: begin r = sx({ins[31:12], 12'h000}); v = 1'b1; end
            7'b0010111: begin r = p + sx({ins[31:12], 12'h000}); v = 1'b1; end
            default: ;
        endcase
    endtask

    task automatic run(input string tag, input logic [31:0] ins, input logic [63:0] a,
                       input logic [63:0] p);
        logic [63:0] er;
        logic        ev;
        logic        es;
        @(posedge clk);
        #1;
        instr = ins;
        rs1   = a;
        pc    = p;
        @(negedge clk);
        model(ins, a, p, er, ev, es);
        n_chk++;
        if (rd !== er || valid !== ev || rsvd !== es) begin
            n_bad++;
            $display("FAIL %s instr=%h rs1=%h: rd=%h valid=%b rsvd=%b expected rd=%h valid=%b rsvd=%b",
                     tag, ins, a, rd, valid, rsvd, er, ev, es);
        end
    endtask

    task automatic pick(input int j, output logic [63:0] v);
        case (j)
            0: v = 64'h8000_0000_8000_0001;
            1: v = 64'h7FFF_FFFF_7FFF_FFFE;
            2: v = 64'hFFFF_FFFF_FFFF_FFFF;
            default: rnd(v);
        endcase
    endtask

    initial begin
        logic [63:0] a;
        logic [63:0] b;
        logic [63:0] p;
        logic [63:0] r1;
        // reset state: opcode zero is unsupported
        run("R9 idle", 32'h0, 64'h0, 64'h0);

        for (int s = 0; s < 64; s++) begin
            for (int j = 0; j < 5; j++) begin
                pick(j, a);
                run("R1 shl", enc_i({6'b000000, 6'(s)}, 3'b001, 7'b0010011), a, 64'h0);
                run("R2 shr log", enc_i({6'b000000, 6'(s)}, 3'b101, 7'b0010011), a, 64'h0);
                run("R2 shr ari", enc_i({6'b010000, 6'(s)}, 3'b101, 7'b0010011), a, 64'h0);
            end
        end

        for (int s = 0; s < 32; s++) begin
            for (int j = 0; j < 5; j++) begin
                pick(j, a);
                run("R4 shlw", enc_i({7'b0000000, 5'(s)}, 3'b001, 7'b0011011), a, 64'h0);
                run("R4 shrw log", enc_i({7'b0000000, 5'(s)}, 3'b101, 7'b0011011), a, 64'h0);
                run("R4 shrw ari", enc_i({7'b0100000, 5'(s)}, 3'b101, 7'b0011011), a, 64'h0);
            end
        end

        for (int k = 0; k < 96; k++) begin
            rnd(b);
            pick(k % 5, a);
            if (k == 0) b[11:0] = 12'h7FF;
            if (k == 1) b[11:0] = 12'h800;
            if (k == 2) begin a = 64'h0000_0000_7FFF_FFFF; b[11:0] = 12'h001; end
            run("R3 addw", enc_i(b[11:0], 3'b000, 7'b0011011), a, 64'h0);
        end

        // R5: same low half, different upper half, identical result
        for (int k = 0; k < 16; k++) begin
            rnd(a);
            rnd(b);
            instr = enc_i({7'b0100000, 5'(k)}, 3'b101, 7'b0011011);
            run("R5 upper ignored a", instr, {a[63:32], a[31:0]}, 64'h0);
            r1 = rd;
            run("R5 upper ignored b", instr, {b[63:32], a[31:0]}, 64'h0);
            n_chk++;
            if (rd !== r1) begin
                n_bad++;
                $display("FAIL R5 rd=%h expected=%h", rd, r1);
            end
        end

        for (int s = 0; s < 32; s++) begin
            rnd(b);
            rs1 = b;
            run("R6 rsvd shl", enc_i({b[11:6], 1'b1, 5'(s)}, 3'b001, 7'b0011011), b, 64'h0);
            run("R6 rsvd shr", enc_i({b[17:12], 1'b1, 5'(s)}, 3'b101, 7'b0011011), b, 64'h0);
        end

        for (int k = 0; k < 64; k++) begin
            rnd(b);
            rnd(p);
            if (k == 0) b[31:12] = 20'h80000;
            if (k == 1) b[31:12] = 20'h7FFFF;
            if (k == 2) p = 64'hFFFF_FFFF_FFFF_FFFF;
            run("R7 ldup", enc_u(b[31:12], 7'b0110111), b, p);
            run("R8 pcup", enc_u(b[31:12], 7'b0010111), b, p);
        end

        for (int f = 0; f < 8; f++) begin
            rnd(b);
            if (f != 1 && f != 5)
                run("R9 op-imm funct3", enc_i(b[11:0], 3'(f), 7'b0010011), b, 64'h0);
            if (f != 0 && f != 1 && f != 5)
                run("R9 word funct3", enc_i(b[11:0], 3'(f), 7'b0011011), b, 64'h0);
        end
        run("R9 shl bad top", enc_i({6'b010000, 6'd3}, 3'b001, 7'b0010011), 64'h1, 64'h0);
        run("R9 shr bad top", enc_i({6'b100000, 6'd3}, 3'b101, 7'b0010011), 64'h1, 64'h0);
        run("R9 shlw bad top", enc_i({7'b0100000, 5'd3}, 3'b001, 7'b0011011), 64'h1, 64'h0);
        run("R9 shrw bad top", enc_i({7'b1000000, 5'd3}, 3'b101, 7'b0011011), 64'h1, 64'h0);
        for (int k = 0; k < 64; k++) begin
            rnd(b);
            if (b[6:0] != 7'b0010011 && b[6:0] != 7'b0011011 &&
                b[6:0] != 7'b0110111 && b[6:0] != 7'b0010111)
                run("R9 other opcode", b[31:0], b, b);
        end

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule